// File: doc/BRIEF.md
# Write-Through Store Buffer

This block sits between a write-through cache and the next memory level. Every store the processor retires is copied into a short first-in first-out queue of address and data pairs. The processor moves on at once unless the queue is full. A store that missed the cache goes into the queue the same way and needs no line fetch. In the background the queue drains its oldest entry to memory. Each memory write occupies a fixed number of cycles, and only one write is outstanding at a time.

Loads probe the queue with their address. When one or more pending entries match, the block returns the data of the youngest matching entry. The load path then sees every store that has not reached memory yet. An empty flag lets a fence or a line replacement wait until all pending writes have reached memory.

Top module: `wt_store_buffer`

## Requirements
- R1: After reset the buffer is empty (`sb_empty`=1), `st_stall`=0 for any request, and `mem_req`, `mem_busy` and `ld_hit` are 0.
- R2: A store (`st_valid`=1) presented while fewer than DEPTH entries are held is accepted in that cycle with `st_stall`=0.
- R3: A store presented while DEPTH entries are held and no memory write completes in that cycle sees `st_stall`=1 and is not taken. It must be presented again.
- R4: A store presented while the buffer is full, in the same cycle the oldest entry's memory write completes, is accepted without a stall.
- R5: Entries reach memory strictly in arrival order. `mem_req` is a one-cycle pulse carrying the oldest entry on `mem_addr`/`mem_data`.
- R6: Only one memory write is outstanding. A write launched by `mem_req` in cycle t keeps `mem_busy`=1 in cycles t+1 to t+WR_LAT. The entry leaves at the end of cycle t+WR_LAT. The next `mem_req` comes no earlier than cycle t+WR_LAT+1.
- R7: `ld_hit`=1 exactly when an entry held at the start of the cycle has address `ld_addr`. `ld_data` is then the data of the newest such entry. A store accepted in the same cycle is not visible to that load.
- R8: `sb_empty`=1 exactly when no entry is held. An entry stays held, and visible to loads, until its memory write has completed.
- R9: `mem_addr` and `mem_data` stay unchanged for the whole time a write is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Processor presents a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_stall | output | 1 | Store refused this cycle (buffer full) |
| ld_addr | input | AW | Load address to probe |
| ld_hit | output | 1 | A pending entry matches `ld_addr` |
| ld_data | output | DW | Data of the newest matching entry |
| mem_req | output | 1 | Pulse: a memory write starts this cycle |
| mem_addr | output | AW | Address of the oldest entry |
| mem_data | output | DW | Data of the oldest entry |
| mem_busy | output | 1 | A memory write is outstanding |
| sb_empty | output | 1 | No entry held |

## Verification
On every cycle, the embedded properties check that occupancy never goes past DEPTH and never drops below zero. They also check that each launch is followed by a busy period that ends after its completion, and that the memory address and data hold still while a write is outstanding. A load hit in an empty buffer is flagged as well. Some behaviours only the bench scenarios can show. These are that drain order matches acceptance order, that a store landing on the completion cycle of a full buffer is accepted, and that the youngest of several same-address entries supplies the load data. The bench also shows that a store in the same cycle stays invisible to the load.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic {
    DR_IDLE  = 1'b0,
    DR_WRITE = 1'b1
  } drain_state_t;

endpackage

// File: rtl/sb_fifo.sv
module sb_fifo #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [AW-1:0]              push_addr,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [AW-1:0]              head_addr,
  output logic [DW-1:0]              head_data,
  output logic [$clog2(DEPTH):0]     occ,
  output logic [$clog2(DEPTH)-1:0]   rd_ptr,
  output logic [DEPTH-1:0]           slot_vld,
  output logic [DEPTH-1:0][AW-1:0]   slot_addr,
  output logic [DEPTH-1:0][DW-1:0]   slot_data
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int OCC_W = PTR_W + 1;

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic [DEPTH-1:0] vld_q, vld_d;

  // next state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    occ_d    = occ_q;
    vld_d    = vld_q;
    if (pop) begin
      rd_ptr_d        = rd_ptr_q + 1'b1;
      vld_d[rd_ptr_q] = 1'b0;
    end
    if (push) begin
      wr_ptr_d        = wr_ptr_q + 1'b1;
      vld_d[wr_ptr_q] = 1'b1;
    end
    case ({push, pop})
      2'b10:   occ_d = occ_q + 1'b1;
      2'b01:   occ_d = occ_q - 1'b1;
      default: occ_d = occ_q;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
      vld_q    <= '0;
    end else if (push || pop) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      occ_q    <= occ_d;
      vld_q    <= vld_d;
    end
  end

  // payload storage, no reset
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic slot_we;
    assign slot_we = push && (wr_ptr_q == PTR_W'(s));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        slot_addr[s] <= push_addr;
        slot_data[s] <= push_data;
      end
    end
  end

  assign head_addr = slot_addr[rd_ptr_q];
  assign head_data = slot_data[rd_ptr_q];
  assign occ       = occ_q;
  assign rd_ptr    = rd_ptr_q;
  assign slot_vld  = vld_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && occ_q == OCC_W'(DEPTH)) |-> pop);
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (occ_q != '0));
  // R2
  occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (occ_q == $past(occ_q) + 1'b1));

endmodule

// File: rtl/sb_drain.sv
module sb_drain
  import sb_pkg::*;
#(
  parameter int WR_LAT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic have_entry,
  output logic launch,
  output logic done,
  output logic in_flight
);

  localparam int TMR_W = (WR_LAT < 2) ? 1 : $clog2(WR_LAT);

  drain_state_t st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic tmr_en;

  assign launch    = (st_q == DR_IDLE) && have_entry;
  assign done      = (st_q == DR_WRITE) && (tmr_q == '0);
  assign in_flight = (st_q == DR_WRITE);

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    tmr_en = 1'b0;
    if (launch) begin
      st_d   = DR_WRITE;
      tmr_d  = TMR_W'(WR_LAT - 1);
      tmr_en = 1'b1;
    end else if (done) begin
      st_d   = DR_IDLE;
    end else if (st_q == DR_WRITE) begin
      tmr_d  = tmr_q - 1'b1;
      tmr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= DR_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
    end
  end

  // R6
  launch_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (in_flight && !launch));
  // R6
  finish_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !in_flight);

endmodule

// File: rtl/sb_match.sv
module sb_match #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic [DEPTH-1:0]           slot_vld,
  input  logic [DEPTH-1:0][AW-1:0]   slot_addr,
  input  logic [DEPTH-1:0][DW-1:0]   slot_data,
  input  logic [$clog2(DEPTH)-1:0]   rd_ptr,
  input  logic [AW-1:0]              ld_addr,
  output logic                       hit,
  output logic [DW-1:0]              hit_data
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0] eq;

  for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
    assign eq[s] = slot_vld[s] && (slot_addr[s] == ld_addr);
  end

  // walk from oldest to newest; the last match wins
  always_comb begin
    logic [PTR_W-1:0] idx;
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = rd_ptr + PTR_W'(k);
      if (eq[idx]) begin
        hit      = 1'b1;
        hit_data = slot_data[idx];
      end
    end
  end

endmodule

// File: rtl/wt_store_buffer.sv
module wt_store_buffer #(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int DEPTH  = 4,
  parameter int WR_LAT = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_stall,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          mem_busy,
  output logic          sb_empty
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int OCC_W = PTR_W + 1;

  logic                     push, pop, full, launch, done, in_flight;
  logic [OCC_W-1:0]         occ;
  logic [PTR_W-1:0]         rd_ptr;
  logic [DEPTH-1:0]         slot_vld;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [DEPTH-1:0][DW-1:0] slot_data;

  assign full     = (occ == OCC_W'(DEPTH));
  assign st_stall = st_valid && full && !done;
  assign push     = st_valid && !st_stall;
  assign pop      = done;
  assign sb_empty = (occ == '0);
  assign mem_req  = launch;
  assign mem_busy = in_flight;

  sb_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (st_addr),
    .push_data (st_data),
    .pop       (pop),
    .head_addr (mem_addr),
    .head_data (mem_data),
    .occ       (occ),
    .rd_ptr    (rd_ptr),
    .slot_vld  (slot_vld),
    .slot_addr (slot_addr),
    .slot_data (slot_data)
  );

  sb_drain #(.WR_LAT(WR_LAT)) drain_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .have_entry (!sb_empty),
    .launch     (launch),
    .done       (done),
    .in_flight  (in_flight)
  );

  sb_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) match_i (
    .slot_vld  (slot_vld),
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .rd_ptr    (rd_ptr),
    .ld_addr   (ld_addr),
    .hit       (ld_hit),
    .hit_data  (ld_data)
  );

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight && !done) |=> ($stable(mem_addr) && $stable(mem_data)));
  // R7
  hit_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> !sb_empty);
  // R8
  busy_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_busy |-> !sb_empty);

endmodule

// File: tb/wt_store_buffer_tb_top.sv
module wt_store_buffer_tb_top;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 4;
  localparam int LAT = 5;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } ent_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          st_valid;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic          st_stall;
  logic [AW-1:0] ld_addr;
  logic          ld_hit;
  logic [DW-1:0] ld_data;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic          mem_busy;
  logic          sb_empty;

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  ent_t q[$];
  bit   busy_m = 1'b0;
  int   rem = 0;

  always #5 clk = ~clk;

  wt_store_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .WR_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_stall(st_stall), .ld_addr(ld_addr),
    .ld_hit(ld_hit), .ld_data(ld_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_busy(mem_busy),
    .sb_empty(sb_empty)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_hit(input logic [AW-1:0] a, output logic [DW-1:0] d);
    model_hit = 1'b0;
    d = '0;
    foreach (q[i]) if (q[i].a == a) begin
      model_hit = 1'b1;
      d = q[i].d;
    end
  endfunction

  // one cycle: drive at negedge, check before posedge, advance model after
  task automatic step(input bit v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [AW-1:0] la);
    bit launch_m, done_m, full_m, stall_m, h;
    logic [DW-1:0] hd;
    @(negedge clk);
    st_valid = v; st_addr = a; st_data = d; ld_addr = la;
    #1;
    launch_m = !busy_m && q.size() > 0;
    done_m   = busy_m && rem == 0;
    full_m   = q.size() == DEPTH;
    stall_m  = v && full_m && !done_m;
    if (v && full_m && done_m)
      chk(st_stall == 1'b0, "R4 full+drain accept", st_stall, 0);
    else if (v && full_m)
      chk(st_stall == 1'b1, "R3 stall on full", st_stall, 1);
    else
      chk(st_stall == 1'b0, "R2 no stall", st_stall, 0);
    chk(mem_req == launch_m, "R5 mem_req timing", mem_req, launch_m);
    if (launch_m && mem_req)
      chk({mem_addr, mem_data} == q[0], "R5 drain order", {mem_addr, mem_data}, q[0]);
    chk(mem_busy == busy_m, "R6 busy window", mem_busy, busy_m);
    if (busy_m)
      chk({mem_addr, mem_data} == q[0], "R9 held addr/data", {mem_addr, mem_data}, q[0]);
    h = model_hit(la, hd);
    chk(ld_hit == h, "R7 load hit", ld_hit, h);
    if (h && ld_hit) chk(ld_data == hd, "R7 newest data", ld_data, hd);
    chk(sb_empty == (q.size() == 0), "R8 empty flag", sb_empty, q.size() == 0);
    @(posedge clk);
    if (done_m) begin
      void'(q.pop_front());
      busy_m = 1'b0;
    end
    if (launch_m) begin
      busy_m = 1'b1;
      rem = LAT - 1;
    end else if (busy_m) begin
      rem = rem - 1;
    end
    if (v && !stall_m) q.push_back({a, d});
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #2_000_000;
    if (!done_run) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int rate;
    void'($urandom(32'd4242));
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; ld_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    st_valid = 1'b1;
    #1;
    // R1 reset state
    chk(sb_empty == 1'b1, "R1 empty", sb_empty, 1);
    chk(st_stall == 1'b0, "R1 stall", st_stall, 0);
    chk(mem_req == 1'b0 && mem_busy == 1'b0, "R1 mem idle", {mem_req, mem_busy}, 0);
    chk(ld_hit == 1'b0, "R1 ld_hit", ld_hit, 0);
    st_valid = 1'b0;
    rst_n = 1'b1;
    // directed: same address twice, load must get second; same-cycle store hidden
    step(1, 16'h0010, 32'h1111_0001, 16'h0010);
    step(1, 16'h0010, 32'h2222_0002, 16'h0010);
    step(1, 16'h0020, 32'h3333_0003, 16'h0010);
    step(1, 16'h0030, 32'h4444_0004, 16'h0030);
    step(1, 16'h0040, 32'h5555_0005, 16'h0040);
    repeat (12) step(1, 16'h0050, 32'h6666_0006, 16'h0050);
    repeat (40) step(0, '0, '0, 16'h0010);
    // random phases
    for (int ph = 0; ph < 3; ph++) begin
      rate = (ph == 0) ? 90 : (ph == 1) ? 25 : 60;
      for (int c = 0; c < 1500; c++)
        step(($urandom % 100) < rate, AW'($urandom % 8), $urandom, AW'($urandom % 8));
    end
    repeat (40) step(0, '0, '0, '0);
    done_run = 1'b1;
    summary();
    $finish;
  end

endmodule